// File: doc/BRIEF.md
# Register-Pair Shift Unit

This block is the shift datapath of a 16-bit processor. It shifts either one 16-bit register or a 32-bit pair. The pair is built from two registers with the high word first. It performs logical and arithmetic shifts in both directions, and 32-bit rotates in both directions. Alongside the shifted value it produces a three-flag condition code: greater than zero (G), less than zero (L) and carry (C).

Decode supplies the two operand words, a raw count field and a four-bit operation code, and pulses `start_i`. One clock later the block presents the result halves and flags with a one-cycle `done_o`. The result stays on the outputs until the next start. A new start is accepted on every cycle. Register write-back and instruction decode sit outside the block.

Top module: `regpair_shifter`

## Requirements
- R1: `done_o` is high in exactly the cycle after each cycle with `start_i` high. The result and flags are captured at that edge and stay unchanged while `start_i` is low. Starts on consecutive cycles each produce their own result.
- R2: `op_i[3]` selects the 32-bit pair when 1. `op_i[2:0]` selects the kind: 0 logical right, 1 logical left, 2 arithmetic right, 3 arithmetic left, 4 rotate right, 5 rotate left. Kinds 4 and 5 always act on the pair. Kinds 6 and 7 pass the operand through with C clear.
- R3: A single-word operation uses only `cnt_i[3:0]` and a pair operation uses only `cnt_i[4:0]`. Higher count bits have no effect.
- R4: On a logical or arithmetic right shift by a nonzero count n, C is bit n-1 of the original operand. With a zero count, C is 0 for every kind.
- R5: On a single-word logical left shift by nonzero n, C is the bit pushed to position 16, which is original bit 16-n.
- R6: An arithmetic left shift keeps the original sign bit and fills the remaining bits from the operand shifted left by n. C is the bit that the shift carried into the sign position.
- R7: An arithmetic right shift fills the vacated bits with the sign bit of the 16-bit word, or of the 32-bit pair for pair operations.
- R8: On a pair logical left shift by nonzero n, C is bit 32-n of the original pair.
- R9: Rotates wrap bits around the 32-bit pair. A zero count leaves the pair unchanged, and C is always 0.
- R10: `cc_o` bit 2 is G, bit 1 is L and bit 0 is C. L is the result's sign bit, and G is set when the result is nonnegative and nonzero. For pair operations both are judged on the full 32-bit result.
- R11: For a pair operation, `res_hi_o` and `res_lo_o` are the upper and lower halves of the 32-bit result. For a single-word operation, `res_hi_o` is the 16-bit result and `res_lo_o` echoes `opnd_lo_i`.
- R12: While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation strobe |
| op_i | input | 4 | Pair select (bit 3) and shift kind (bits 2:0) |
| opnd_hi_i | input | 16 | Single operand, or high word of the pair |
| opnd_lo_i | input | 16 | Low word of the pair |
| cnt_i | input | 8 | Raw shift count field |
| res_hi_o | output | 16 | Result word, or high half of the pair result |
| res_lo_o | output | 16 | Low half of the pair result, or echoed low operand |
| cc_o | output | 3 | Flags {G, L, C} |
| done_o | output | 1 | Result valid pulse |

## Verification
Capture of a new result and presentation of the previous one can occur in the same cycle. This happens when decode issues starts on consecutive cycles. The bench drives two differing operations back to back. It checks that the second result replaces the first exactly one cycle later, with `done_o` held high across both cycles. It then checks that `done_o` drops and the last result is held once the strobe goes away.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

   typedef enum logic [2:0] {
      SK_LOG_R = 3'd0,
      SK_LOG_L = 3'd1,
      SK_ARI_R = 3'd2,
      SK_ARI_L = 3'd3,
      SK_ROT_R = 3'd4,
      SK_ROT_L = 3'd5,
      SK_RSV_6 = 3'd6,
      SK_RSV_7 = 3'd7
   } shift_kind_e;

   typedef struct packed {
      logic g;
      logic l;
      logic c;
   } cond_t;

endpackage

// File: rtl/shifter_lane.sv
module shifter_lane
   import shifter_pkg::*;
#(
   parameter int W       = 16,
   parameter bit HAS_ROT = 1'b0,
   localparam int CW     = $clog2(W)
) (
   input  logic [W-1:0]  opnd_i,
   input  logic [CW-1:0] cnt_i,
   input  shift_kind_e   kind_i,
   output logic [W-1:0]  res_o,
   output logic          carry_o
);

   logic [CW-1:0] cnt_m1;
   logic          cnt_nz;
   logic [W:0]    lsh_ext;
   logic [W-1:0]  srl_v;
   logic [W-1:0]  sra_v;
   logic [W-1:0]  sla_v;
   logic [W-1:0]  rotr_v;
   logic [W-1:0]  rotl_v;
   logic          rcarry;

   assign cnt_m1  = cnt_i - CW'(1);
   assign cnt_nz  = |cnt_i;
   assign lsh_ext = {1'b0, opnd_i} << cnt_i;
   assign srl_v   = opnd_i >> cnt_i;
   assign sra_v   = $unsigned($signed(opnd_i) >>> cnt_i);
   assign sla_v   = {opnd_i[W-1], lsh_ext[W-2:0]};
   assign rcarry  = cnt_nz & opnd_i[cnt_m1];

   generate
      if (HAS_ROT) begin : g_rot
         logic [2*W-1:0] dbl;
         logic [2*W-1:0] dbl_r;
         logic [2*W-1:0] dbl_l;
         assign dbl    = {opnd_i, opnd_i};
         assign dbl_r  = dbl >> cnt_i;
         assign dbl_l  = dbl << cnt_i;
         assign rotr_v = dbl_r[W-1:0];
         assign rotl_v = dbl_l[2*W-1:W];
      end else begin : g_norot
         assign rotr_v = opnd_i;
         assign rotl_v = opnd_i;
      end
   endgenerate

   always_comb begin
      res_o   = opnd_i;
      carry_o = 1'b0;
      case (kind_i)
         SK_LOG_R: begin res_o = srl_v;         carry_o = rcarry;                 end
         SK_LOG_L: begin res_o = lsh_ext[W-1:0]; carry_o = cnt_nz & lsh_ext[W];   end
         SK_ARI_R: begin res_o = sra_v;         carry_o = rcarry;                 end
         SK_ARI_L: begin res_o = sla_v;         carry_o = cnt_nz & lsh_ext[W-1]; end
         SK_ROT_R: res_o = rotr_v;
         SK_ROT_L: res_o = rotl_v;
         default:  res_o = opnd_i;
      endcase
   end

endmodule

// File: rtl/shifter_flags.sv
module shifter_flags #(
   parameter int W = 16
) (
   input  logic [W-1:0] val_i,
   output logic         g_o,
   output logic         l_o
);

   assign l_o = val_i[W-1];
   assign g_o = ~val_i[W-1] & (|val_i[W-2:0]);

endmodule

// File: rtl/regpair_shifter.sv
module regpair_shifter
   import shifter_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int CNT_IN_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [3:0]          op_i,
   input  logic [DATA_W-1:0]   opnd_hi_i,
   input  logic [DATA_W-1:0]   opnd_lo_i,
   input  logic [CNT_IN_W-1:0] cnt_i,
   output logic [DATA_W-1:0]   res_hi_o,
   output logic [DATA_W-1:0]   res_lo_o,
   output logic [2:0]          cc_o,
   output logic                done_o
);

   localparam int PAIR_W = 2 * DATA_W;
   localparam int SCW    = $clog2(DATA_W);
   localparam int PCW    = $clog2(PAIR_W);

   generate
      if (DATA_W < 4 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 4");
      end
      if (CNT_IN_W < PCW) begin : g_bad_cnt
         $error("CNT_IN_W too narrow for pair shift counts");
      end
   endgenerate

   shift_kind_e       kind;
   logic              use_pair;
   logic [DATA_W-1:0] s_res;
   logic              s_c, s_g, s_l;
   logic [PAIR_W-1:0] p_res;
   logic              p_c, p_g, p_l;
   logic [DATA_W-1:0] nx_hi, nx_lo;
   cond_t             nx_cc;

   assign kind     = shift_kind_e'(op_i[2:0]);
   assign use_pair = op_i[3] | (kind == SK_ROT_R) | (kind == SK_ROT_L);

   shifter_lane #(.W(DATA_W), .HAS_ROT(1'b0)) i_lane_single (
      .opnd_i  (opnd_hi_i),
      .cnt_i   (cnt_i[SCW-1:0]),
      .kind_i  (kind),
      .res_o   (s_res),
      .carry_o (s_c)
   );

   shifter_lane #(.W(PAIR_W), .HAS_ROT(1'b1)) i_lane_pair (
      .opnd_i  ({opnd_hi_i, opnd_lo_i}),
      .cnt_i   (cnt_i[PCW-1:0]),
      .kind_i  (kind),
      .res_o   (p_res),
      .carry_o (p_c)
   );

   shifter_flags #(.W(DATA_W)) i_flags_single (
      .val_i (s_res),
      .g_o   (s_g),
      .l_o   (s_l)
   );

   shifter_flags #(.W(PAIR_W)) i_flags_pair (
      .val_i (p_res),
      .g_o   (p_g),
      .l_o   (p_l)
   );

   always_comb begin
      if (use_pair) begin
         nx_hi = p_res[PAIR_W-1:DATA_W];
         nx_lo = p_res[DATA_W-1:0];
         nx_cc = '{g: p_g, l: p_l, c: p_c};
      end else begin
         nx_hi = s_res;
         nx_lo = opnd_lo_i;
         nx_cc = '{g: s_g, l: s_l, c: s_c};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_hi_o <= '0;
         res_lo_o <= '0;
         cc_o     <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            res_hi_o <= nx_hi;
            res_lo_o <= nx_lo;
            cc_o     <= nx_cc;
         end
      end
   end

   AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o); // R1
   AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(start_i)); // R1
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(res_hi_o) && $stable(res_lo_o) && $stable(cc_o))); // R1
   AST_ZERO_COUNT_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && cnt_i[PCW-1:0] == '0) |=> !cc_o[0]); // R4
   AST_SLA_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !op_i[3] && op_i[2:0] == 3'd3) |=> res_hi_o[DATA_W-1] == $past(opnd_hi_i[DATA_W-1])); // R6
   AST_ROTATE_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (op_i[2:0] == 3'd4 || op_i[2:0] == 3'd5)) |=> !cc_o[0]); // R9
   AST_GL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !(cc_o[2] && cc_o[1])); // R10
   AST_SINGLE_LO_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !op_i[3] && op_i[2:1] != 2'b10) |=> res_lo_o == $past(opnd_lo_i)); // R11

endmodule

// File: tb/test_regpair_shifter.sv
module test_regpair_shifter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [3:0]  op_i = '0;
   logic [15:0] opnd_hi_i = '0;
   logic [15:0] opnd_lo_i = '0;
   logic [7:0]  cnt_i = '0;
   logic [15:0] res_hi_o, res_lo_o;
   logic [2:0]  cc_o;
   logic        done_o;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   regpair_shifter i_regpair_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .op_i      (op_i),
      .opnd_hi_i (opnd_hi_i),
      .opnd_lo_i (opnd_lo_i),
      .cnt_i     (cnt_i),
      .res_hi_o  (res_hi_o),
      .res_lo_o  (res_lo_o),
      .cc_o      (cc_o),
      .done_o    (done_o)
   );

   // Bit-serial reference built from the requirement text
   task automatic model(input logic [3:0] op, input logic [15:0] hi, input logic [15:0] lo,
                        input logic [7:0] cnt, output logic [15:0] eh, output logic [15:0] el,
                        output logic [2:0] ecc);
      logic [31:0] v;
      logic [2:0]  k;
      logic        pr, c, s, b, gl_l, gl_g;
      int          w, n;
      k  = op[2:0];
      pr = op[3] || k == 3'd4 || k == 3'd5;
      w  = pr ? 32 : 16;
      n  = pr ? int'(cnt & 8'd31) : int'(cnt & 8'd15);
      v  = pr ? {hi, lo} : {16'h0, hi};
      c  = 1'b0;
      s  = v[w-1];
      for (int i = 0; i < n; i++) begin
         case (k)
            3'd0: begin c = v[0]; v = v >> 1; end
            3'd1: begin c = v[w-1]; v = v << 1; if (w == 16) v[31:16] = '0; end
            3'd2: begin c = v[0]; b = v[w-1]; v = v >> 1; v[w-1] = b; end
            3'd3: begin c = v[w-2]; v = v << 1; if (w == 16) v[31:16] = '0; v[w-1] = s; end
            3'd4: begin b = v[0]; v = v >> 1; v[31] = b; end
            3'd5: begin b = v[31]; v = v << 1; v[0] = b; end
            default: ;
         endcase
      end
      if (k == 3'd4 || k == 3'd5) c = 1'b0;
      gl_l = v[w-1];
      gl_g = !gl_l && (v != 32'h0);
      ecc  = {gl_g, gl_l, c};
      eh   = pr ? v[31:16] : v[15:0];
      el   = pr ? v[15:0] : lo;
   endtask

   task automatic check_out(input string tag, input logic [15:0] eh, input logic [15:0] el,
                            input logic [2:0] ecc, input logic edone);
      n_run++;
      if (res_hi_o !== eh || res_lo_o !== el || cc_o !== ecc || done_o !== edone) begin
         n_fail++;
         $display("FAIL %s: got hi=%h lo=%h cc=%b done=%b, expected hi=%h lo=%h cc=%b done=%b",
                  tag, res_hi_o, res_lo_o, cc_o, done_o, eh, el, ecc, edone);
      end
   endtask

   task automatic drive(input logic [3:0] op, input logic [15:0] hi, input logic [15:0] lo,
                        input logic [7:0] cnt);
      start_i   = 1'b1;
      op_i      = op;
      opnd_hi_i = hi;
      opnd_lo_i = lo;
      cnt_i     = cnt;
   endtask

   task automatic run_op(input string tag, input logic [3:0] op, input logic [15:0] hi,
                         input logic [15:0] lo, input logic [7:0] cnt);
      logic [15:0] eh, el;
      logic [2:0]  ecc;
      model(op, hi, lo, cnt, eh, el, ecc);
      @(negedge clk);
      drive(op, hi, lo, cnt);
      @(negedge clk);
      start_i = 1'b0;
      check_out(tag, eh, el, ecc, 1'b1);
   endtask

   task automatic t_reset;
      check_out("R12 reset state", 16'h0, 16'h0, 3'b000, 1'b0);
   endtask

   task automatic t_single_logical;
      run_op("R4 single right n=3", 4'h0, 16'h8425, 16'hAAAA, 8'd3);
      run_op("R4 single right n=0 no carry", 4'h0, 16'h8001, 16'h1111, 8'd0);
      run_op("R5 single left n=4", 4'h1, 16'h1234, 16'h0F0F, 8'd4);
      run_op("R5 single left carry out", 4'h1, 16'h8001, 16'h0000, 8'd1);
      check_out("R5 explicit", 16'h0002, 16'h0000, 3'b101, 1'b1);
   endtask

   task automatic t_arith;
      run_op("R7 single arith right", 4'h2, 16'h8010, 16'h5555, 8'd4);
      run_op("R6 single arith left", 4'h3, 16'hC001, 16'h0000, 8'd1);
      check_out("R6 explicit sign kept", 16'h8002, 16'h0000, 3'b011, 1'b1);
      run_op("R6 single arith left to zero", 4'h3, 16'h4000, 16'h0000, 8'd1);
      check_out("R6 explicit zero result", 16'h0000, 16'h0000, 3'b001, 1'b1);
      run_op("R7 pair arith right", 4'hA, 16'h9000, 16'h0003, 8'd18);
      run_op("R6 pair arith left", 4'hB, 16'h2345, 16'h6789, 8'd3);
   endtask

   task automatic t_pair;
      run_op("R4 pair right n=17", 4'h8, 16'h0003, 16'hFFFF, 8'd17);
      run_op("R8 pair left n=16", 4'h9, 16'h0001, 16'h8000, 8'd16);
      run_op("R8 pair left n=31", 4'h9, 16'h1234, 16'h0003, 8'd31);
      run_op("R10 pair G from low half", 4'h8, 16'h0000, 16'h0100, 8'd1);
      check_out("R10 explicit", 16'h0000, 16'h0080, 3'b100, 1'b1);
      run_op("R11 pair halves", 4'h8, 16'hF00F, 16'h1234, 8'd8);
   endtask

   task automatic t_rotate;
      run_op("R9 rotate right n=8", 4'h4, 16'h1234, 16'h5678, 8'd8);
      check_out("R9 explicit", 16'h7812, 16'h3456, 3'b100, 1'b1);
      run_op("R9 rotate left n=31", 4'hD, 16'h8000, 16'h0001, 8'd31);
      run_op("R9 rotate left n=0", 4'h5, 16'hABCD, 16'h0123, 8'd0);
   endtask

   task automatic t_mask;
      run_op("R3 single count high bits", 4'h0, 16'hF0F4, 16'h0000, 8'h13);
      run_op("R3 pair count high bits", 4'h9, 16'h0F00, 16'h00F0, 8'hE5);
      run_op("R3 single count 16 is zero", 4'h1, 16'h8421, 16'h0000, 8'h10);
      check_out("R3 explicit", 16'h8421, 16'h0000, 3'b010, 1'b1);
   endtask

   task automatic t_reserved;
      run_op("R2 reserved kind passes", 4'h6, 16'h7001, 16'h0002, 8'd5);
      check_out("R2 explicit", 16'h7001, 16'h0002, 3'b100, 1'b1);
   endtask

   task automatic t_back_to_back;
      logic [15:0] ah, al, bh, bl;
      logic [2:0]  ac, bc;
      model(4'h1, 16'h00F0, 16'h1111, 8'd4, ah, al, ac);
      model(4'hA, 16'h8000, 16'h0000, 8'd1, bh, bl, bc);
      @(negedge clk);
      drive(4'h1, 16'h00F0, 16'h1111, 8'd4);
      @(negedge clk);
      check_out("R1 first of pair", ah, al, ac, 1'b1);
      drive(4'hA, 16'h8000, 16'h0000, 8'd1);
      @(negedge clk);
      start_i = 1'b0;
      check_out("R1 second replaces first", bh, bl, bc, 1'b1);
      opnd_hi_i = 16'hFFFF;
      cnt_i     = 8'd7;
      @(negedge clk);
      check_out("R1 idle holds result", bh, bl, bc, 1'b0);
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_single_logical();
      t_arith();
      t_pair();
      t_rotate();
      t_mask();
      t_reserved();
      t_back_to_back();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule